// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns a 64-bit DMA address that arrives from a PCI bus into a system physical address. Four programmable windows each decide whether an incoming address falls inside them. A window that matches either relocates the address directly or performs a single-level page-table lookup with 8 KB pages. Addresses that fit in 32 bits are single-cycle addresses. Wider addresses are dual-cycle addresses and can reach two further paths: a large identity window and a table-walked path that belongs to the last window.

Software programs the windows through a small register port. Each window has a base register, a mask register and a translated-base register. One control register holds the hole enable in bit 5 and the identity-window enable in bit 6. A requester hands in one address at a time using a ready/valid pair. The result is held with `rsp_valid` until `rsp_ready` accepts it. A page-table entry is fetched through a request/response memory port, and the block waits for the memory response before it completes.

Top module: `dma_xlat`

## Requirements
- R1: After reset, every base register reads 0, except the last window's base, which reads 0x2. Mask, translated-base and control registers read 0. `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The register address is group × 0x100 + window × 0x40, where group 0 is base, 1 is mask and 2 is translated base. A base write to windows 0–2 keeps bits 31:20 and 1:0. A base write to the last window keeps bits 39, 31:20 and 0, and always reads bit 1 as 1. In a base register, bit 0 enables the window, bit 1 selects the table walk, and bit 39 (last window only) routes the window to dual-cycle addresses.
- R3: A mask write keeps bits 31:20. A translated-base write keeps bits 34:10. The control register sits at 0x300 and keeps bits 6:5. Reads return the stored value zero-extended to 64 bits.
- R4: With ext = mask | 0xFFFFF, an enabled window matches a single-cycle address when (addr & ~ext) equals base bits 31:20 placed at 31:20. A matching direct window returns hit with phys = (tba & ~ext) | (addr & ext), and no memory access is made.
- R5: For single-cycle addresses, windows are tried in index order and the lowest matching index wins. The last window takes part only while its bit 39 is clear.
- R6: While control bit 5 is set, single-cycle addresses 0x80000 to 0xFFFFF fault, even if a window covers them. While bit 5 is clear, windows translate those addresses normally.
- R7: A matching walk window issues one memory read at (tba & ~(mask >> 10)) | ((addr & (mask | 0xFE000)) >> 10). The block holds the request address until `mem_req_ready` is seen. If entry bit 0 is set, the result is phys = (entry bits 21:1 placed at 33:13) | addr bits 12:0.
- R8: A fetched entry with bit 0 clear gives a fault. Every fault reports `rsp_hit` = 0 and `rsp_phys` = 0.
- R9: While control bit 6 is set, a dual-cycle address in [0x100_0000_0000, 0x200_0000_0000) returns hit with phys = addr bits 34:0.
- R10: A dual-cycle address in [0x800_0000_0000, 0xFFF_FFFF_FFFF] walks the table through the last window when both its bits 39 and 0 are set. The entry address is (tba & 0x7_FFC0_0000) | ((addr & 0xFFFFE000) >> 10). If either bit is clear, such an address faults.
- R11: An address that reaches no window or path faults, and a disabled window never matches.
- R12: `req_ready` is 1 only while no translation is in progress. `rsp_valid`, `rsp_hit` and `rsp_phys` stay unchanged until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 64 | PCI DMA address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_hit | output | 1 | 1 = translated, 0 = fault |
| rsp_phys | output | 35 | Physical address, 0 on fault |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 35 | Table-entry physical address |
| mem_rsp_valid | input | 1 | Table entry returned |
| mem_rsp_data | input | 64 | Table-entry contents |

## Verification
The hardest situations to reach from the ports are the ones where two paths compete for one address. Examples are a direct window overlapping a catch-all walk window, the hole sitting on top of a live window, and the last window switching between the single-cycle and dual-cycle paths. A fixed configuration is programmed so that the overlaps exist, and a vector table then drives addresses through each path and onto each range edge. Afterwards the hole, the last window's routing bit and a window's enable are reprogrammed one at a time, and addresses that were resolved before are sent again. Back-pressure on the memory port and on the response is applied in separate directed runs.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
   localparam int BASE_W    = 40;   // stored base width (routing bit lives at 39)
   localparam int WIN_AW    = 32;   // single-cycle address width
   localparam int PA_W      = 35;   // physical address width
   localparam int PAGE_BITS = 13;   // 8 KB table pages
   localparam int DIRECT_LO = 20;   // windows are at least 1 MB

   localparam int B_EN      = 0;
   localparam int B_SG      = 1;
   localparam int B_DAC     = 39;
   localparam int C_HOLE    = 0;    // index in stored control (bit 5 of the register)
   localparam int C_IDENT   = 1;    // index in stored control (bit 6 of the register)

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [WIN_AW-1:0] mask;
      logic [PA_W-1:0]   tba;
   } win_cfg_t;

   typedef enum logic [1:0] {
      XL_FAULT = 2'd0,
      XL_HIT   = 2'd1,
      XL_WALK  = 2'd2
   } xl_kind_e;

   typedef struct packed {
      xl_kind_e          kind;
      logic [PA_W-1:0]   pa;
      logic [PA_W-1:0]   pte_addr;
   } xl_dec_t;
endpackage

// File: rtl/dma_xlat_regs.sv
module dma_xlat_regs
   import dma_xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int CFG_AW  = 10,
   parameter int DATA_W  = 64
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [CFG_AW-1:0]         cfg_addr,
   input  logic [DATA_W-1:0]         cfg_wdata,
   output logic [DATA_W-1:0]         cfg_rdata,
   output win_cfg_t [NUM_WIN-1:0]    win,
   output logic                      hole_en,
   output logic                      ident_en
);
   localparam int IDX_W = 2;
   localparam int LAST  = NUM_WIN - 1;

   logic [1:0]       grp;
   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic [1:0]       ctl_q;

   assign grp     = cfg_addr[9:8];
   assign idx     = cfg_addr[7:6];
   assign aligned = (cfg_addr[5:0] == 6'd0);

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic              sel;
      logic [BASE_W-1:0] base_q;
      logic [WIN_AW-1:0] mask_q;
      logic [PA_W-1:0]   tba_q;

      assign sel = cfg_we && aligned && (idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= (i == LAST) ? BASE_W'(2) : '0;
            mask_q <= '0;
            tba_q  <= '0;
         end else if (sel) begin
            case (grp)
               2'd0: begin
                  if (i == LAST)
                     base_q <= {cfg_wdata[39], 7'b0, cfg_wdata[31:20], 18'b0, 1'b1, cfg_wdata[0]};
                  else
                     base_q <= {8'b0, cfg_wdata[31:20], 18'b0, cfg_wdata[1:0]};
               end
               2'd1: mask_q <= {cfg_wdata[31:20], 20'b0};
               2'd2: tba_q  <= {cfg_wdata[34:10], 10'b0};
               default: ;
            endcase
         end
      end

      assign win[i] = '{base: base_q, mask: mask_q, tba: tba_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (cfg_we && aligned && grp == 2'd3 && idx == '0)
         ctl_q <= cfg_wdata[6:5];
   end

   assign hole_en  = ctl_q[C_HOLE];
   assign ident_en = ctl_q[C_IDENT];

   always_comb begin
      cfg_rdata = '0;
      if (aligned) begin
         if (grp == 2'd3) begin
            if (idx == '0) cfg_rdata = DATA_W'({ctl_q, 5'b0});
         end else begin
            for (int i = 0; i < NUM_WIN; i++) begin
               if (idx == IDX_W'(i)) begin
                  case (grp)
                     2'd0:    cfg_rdata = DATA_W'(win[i].base);
                     2'd1:    cfg_rdata = DATA_W'(win[i].mask);
                     default: cfg_rdata = DATA_W'(win[i].tba);
                  endcase
               end
            end
         end
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{cfg_wdata[DATA_W-1:40], cfg_wdata[38:35], cfg_wdata[9:7], cfg_wdata[4:2]};
endmodule

// File: rtl/dma_xlat_win.sv
module dma_xlat_win
   import dma_xlat_pkg::*;
(
   input  win_cfg_t          cfg,
   input  logic [WIN_AW-1:0] addr,
   output logic              hit,
   output logic              sg,
   output logic [PA_W-1:0]   direct_pa,
   output logic [PA_W-1:0]   pte_addr
);
   logic [WIN_AW-1:0] ext;
   logic [WIN_AW-1:0] sel;
   logic [PA_W-1:0]   mask_sh;

   assign ext = {cfg.mask[WIN_AW-1:DIRECT_LO], {DIRECT_LO{1'b1}}};
   assign hit = cfg.base[B_EN] &&
                ((addr & ~ext) == {cfg.base[WIN_AW-1:DIRECT_LO], {DIRECT_LO{1'b0}}});
   assign sg  = cfg.base[B_SG];

   assign direct_pa = (cfg.tba & ~PA_W'(ext)) | PA_W'(addr & ext);

   // table index: window-relative page number scaled to 8-byte entries
   assign mask_sh  = PA_W'(cfg.mask[WIN_AW-1:10]);
   assign sel      = addr & (cfg.mask | 32'h000F_E000);
   assign pte_addr = (cfg.tba & ~mask_sh) | PA_W'(sel[WIN_AW-1:10]);

   logic unused_cfg;
   assign unused_cfg = ^{cfg.base[BASE_W-1:WIN_AW], cfg.base[DIRECT_LO-1:2],
                         cfg.mask[DIRECT_LO-1:0]};
endmodule

// File: rtl/dma_xlat_route.sv
module dma_xlat_route
   import dma_xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64
)(
   input  logic [ADDR_W-1:0]      addr,
   input  win_cfg_t [NUM_WIN-1:0] win,
   input  logic                   hole_en,
   input  logic                   ident_en,
   output xl_dec_t                dec
);
   localparam int LAST = NUM_WIN - 1;

   logic [NUM_WIN-1:0] w_hit;
   logic [NUM_WIN-1:0] w_sg;
   logic [PA_W-1:0]    w_pa  [NUM_WIN];
   logic [PA_W-1:0]    w_pte [NUM_WIN];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_w
      dma_xlat_win u_win (
         .cfg       (win[i]),
         .addr      (addr[WIN_AW-1:0]),
         .hit       (w_hit[i]),
         .sg        (w_sg[i]),
         .direct_pa (w_pa[i]),
         .pte_addr  (w_pte[i])
      );
   end

   logic sac, in_hole, in_ident, in_dac, last_dac;

   assign sac      = (addr[ADDR_W-1:WIN_AW] == '0);
   assign in_hole  = (addr[WIN_AW-1:20] == '0) && addr[19];
   assign in_ident = (addr[ADDR_W-1:41] == '0) && addr[40];
   assign in_dac   = (addr[ADDR_W-1:44] == '0) && addr[43];
   assign last_dac = win[LAST].base[B_DAC];

   always_comb begin
      logic found;
      found = 1'b0;
      dec   = '{kind: XL_FAULT, pa: '0, pte_addr: '0};
      if (sac) begin
         if (!(hole_en && in_hole)) begin
            for (int i = 0; i < NUM_WIN; i++) begin
               if (!found && w_hit[i] && !(i == LAST && last_dac)) begin
                  found = 1'b1;
                  if (w_sg[i]) begin
                     dec.kind     = XL_WALK;
                     dec.pte_addr = w_pte[i];
                  end else begin
                     dec.kind = XL_HIT;
                     dec.pa   = w_pa[i];
                  end
               end
            end
         end
      end else if (ident_en && in_ident) begin
         dec.kind = XL_HIT;
         dec.pa   = addr[PA_W-1:0];
      end else if (in_dac && last_dac && win[LAST].base[B_EN]) begin
         dec.kind     = XL_WALK;
         dec.pte_addr = (win[LAST].tba & 35'h7_FFC0_0000) |
                        PA_W'({addr[WIN_AW-1:PAGE_BITS], 3'b0});
      end
   end
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
   import dma_xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 64,
   parameter int CFG_AW  = 10
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [DATA_W-1:0]   cfg_wdata,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   output logic                rsp_valid,
   input  logic                rsp_ready,
   output logic                rsp_hit,
   output logic [PA_W-1:0]     rsp_phys,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [PA_W-1:0]     mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [DATA_W-1:0]   mem_rsp_data
);
   if (NUM_WIN < 2 || NUM_WIN > 4) begin : g_bad_win
      $error("dma_xlat: NUM_WIN must be 2 to 4");
   end
   if (ADDR_W != 64 || DATA_W != 64) begin : g_bad_width
      $error("dma_xlat: address and data must be 64 bits");
   end
   if (CFG_AW != 10) begin : g_bad_cfg
      $error("dma_xlat: register offset must be 10 bits");
   end

   typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_e;

   win_cfg_t [NUM_WIN-1:0] win;
   logic                   hole_en, ident_en;
   xl_dec_t                dec;

   st_e                    state;
   logic                   hit_q;
   logic [PA_W-1:0]        pa_q;
   logic [PA_W-1:0]        pte_q;
   logic [PAGE_BITS-1:0]   off_q;

   dma_xlat_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .win       (win),
      .hole_en   (hole_en),
      .ident_en  (ident_en)
   );

   dma_xlat_route #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_route (
      .addr     (req_addr),
      .win      (win),
      .hole_en  (hole_en),
      .ident_en (ident_en),
      .dec      (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         hit_q <= 1'b0;
         pa_q  <= '0;
         pte_q <= '0;
         off_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               off_q <= req_addr[PAGE_BITS-1:0];
               pte_q <= dec.pte_addr;
               case (dec.kind)
                  XL_WALK: begin
                     hit_q <= 1'b0;
                     pa_q  <= '0;
                     state <= S_FETCH;
                  end
                  XL_HIT: begin
                     hit_q <= 1'b1;
                     pa_q  <= dec.pa;
                     state <= S_DONE;
                  end
                  default: begin
                     hit_q <= 1'b0;
                     pa_q  <= '0;
                     state <= S_DONE;
                  end
               endcase
            end
            S_FETCH: if (mem_req_ready) state <= S_WAIT;
            S_WAIT: if (mem_rsp_valid) begin
               hit_q <= mem_rsp_data[0];
               pa_q  <= mem_rsp_data[0] ? PA_W'({mem_rsp_data[21:1], off_q}) : '0;
               state <= S_DONE;
            end
            default: if (rsp_ready) state <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == S_IDLE);
   assign rsp_valid     = (state == S_DONE);
   assign rsp_hit       = hit_q;
   assign rsp_phys      = pa_q;
   assign mem_req_valid = (state == S_FETCH);
   assign mem_req_addr  = pte_q;

   logic unused_rsp;
   assign unused_rsp = ^mem_rsp_data[DATA_W-1:22];
endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk
   import dma_xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int DATA_W  = 64,
   parameter int CFG_AW  = 10
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_hit,
   input logic [PA_W-1:0]   rsp_phys,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [PA_W-1:0]   mem_req_addr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_rdata
);
   localparam logic [CFG_AW-1:0] LAST_BASE = CFG_AW'((NUM_WIN - 1) * 64);

   p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_phys)));

   p_memreq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_memreq_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (!req_ready && !rsp_valid));

   p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_phys == '0));

   p_last_sg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == LAST_BASE) |-> cfg_rdata[B_SG]);
endmodule

bind dma_xlat dma_xlat_chk #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .CFG_AW(CFG_AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_hit       (rsp_hit),
   .rsp_phys      (rsp_phys),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .cfg_addr      (cfg_addr),
   .cfg_rdata     (cfg_rdata)
);

// File: tb/test_dma_xlat.sv
module test_dma_xlat;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [9:0]  cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic        rsp_hit;
   logic [34:0] rsp_phys;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [34:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        mem_gate = 1'b1;

   int tests = 0;
   int fails = 0;
   int mem_hits = 0;
   logic [34:0] mem_last = '0;

   assign mem_req_ready = mem_gate;

   dma_xlat i_dma_xlat (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_hit (rsp_hit), .rsp_phys (rsp_phys),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready), .mem_req_addr (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // table memory: entry frame = address bits 23:3, valid unless address bit 5 is set
   function automatic logic [63:0] pte_model(input logic [34:0] a);
      return {42'b0, a[23:3], ~a[5]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
      end else begin
         mem_rsp_valid <= mem_req_valid && mem_req_ready;
         mem_rsp_data  <= pte_model(mem_req_addr);
         if (mem_req_valid && mem_req_ready) begin
            mem_hits <= mem_hits + 1;
            mem_last <= mem_req_addr;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [9:0] a, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_check(input string req, input logic [9:0] a, input logic [63:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(req, $sformatf("reg %h", a), cfg_rdata, exp);
   endtask

   task automatic wait_rsp();
      int guard = 0;
      while (!rsp_valid && guard < 100) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic xlat(input string req, input logic [63:0] a, input logic exp_hit,
                       input logic [34:0] exp_pa, input logic walk, input logic [34:0] exp_pte);
      int n0;
      n0 = mem_hits;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp();
      chk(req, $sformatf("rsp_valid %h", a), 64'(rsp_valid), 64'd1);
      chk(req, $sformatf("hit %h", a), 64'(rsp_hit), 64'(exp_hit));
      chk(req, $sformatf("phys %h", a), 64'(rsp_phys), 64'(exp_pa));
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req, $sformatf("fetches %h", a), 64'(mem_hits - n0), walk ? 64'd1 : 64'd0);
      if (walk) chk(req, $sformatf("entry addr %h", a), 64'(mem_last), 64'(exp_pte));
   endtask

   typedef struct packed {
      logic [63:0] addr;
      logic [3:0]  req;
      logic        hit;
      logic        walk;
      logic [34:0] pa;
      logic [34:0] pte;
   } vec_t;

   // window 0 direct 0x4000_0000..0x5FFF_FFFF, window 1 walk 0x800x_xxxx,
   // window 2 direct 0x000x_xxxx, window 3 walk catch-all; hole and identity on
   localparam vec_t VECS [14] = '{
      '{64'h0000_0000_4123_4567, 4'd4,  1'b1, 1'b0, 35'h2_2123_4567, 35'h0},          // R4
      '{64'h0000_0000_500A_BCDE, 4'd4,  1'b1, 1'b0, 35'h2_300A_BCDE, 35'h0},          // R4
      '{64'h0000_0000_400F_0000, 4'd5,  1'b1, 1'b0, 35'h2_200F_0000, 35'h0},          // R5
      '{64'h0000_0000_8001_2345, 4'd7,  1'b1, 1'b1, 35'h0_0001_2345, 35'h1_0000_0048}, // R7
      '{64'h0000_0000_8000_8000, 4'd8,  1'b0, 1'b1, 35'h0,           35'h1_0000_0020}, // R8
      '{64'h0000_0000_C000_6000, 4'd7,  1'b1, 1'b1, 35'h1_C000_6000, 35'h0_0070_0018}, // R7
      '{64'h0000_0000_0007_FFFF, 4'd4,  1'b1, 1'b0, 35'h0_0707_FFFF, 35'h0},          // R4
      '{64'h0000_0000_0008_0000, 4'd6,  1'b0, 1'b0, 35'h0,           35'h0},          // R6
      '{64'h0000_0000_000F_FFFF, 4'd6,  1'b0, 1'b0, 35'h0,           35'h0},          // R6
      '{64'h0000_0000_0010_0000, 4'd5,  1'b1, 1'b1, 35'h1_0010_0000, 35'h0_0040_0400}, // R5
      '{64'h0000_0107_8765_4321, 4'd9,  1'b1, 1'b0, 35'h7_8765_4321, 35'h0},          // R9
      '{64'h0000_01FF_FFFF_FFFF, 4'd9,  1'b1, 1'b0, 35'h7_FFFF_FFFF, 35'h0},          // R9
      '{64'h0000_0200_0000_0000, 4'd11, 1'b0, 1'b0, 35'h0,           35'h0},          // R11
      '{64'h0000_0001_0000_0000, 4'd11, 1'b0, 1'b0, 35'h0,           35'h0}           // R11
   };

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      logic [34:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
      cfg_check("R1", 10'h000, 64'h0);
      cfg_check("R1", 10'h080, 64'h0);
      cfg_check("R1", 10'h0C0, 64'h2);
      cfg_check("R1", 10'h100, 64'h0);
      cfg_check("R1", 10'h2C0, 64'h0);
      cfg_check("R1", 10'h300, 64'h0);

      // R2 / R3: write masking
      cfg_write(10'h000, '1);  cfg_check("R2", 10'h000, 64'hFFF0_0003);
      cfg_write(10'h0C0, '1);  cfg_check("R2", 10'h0C0, 64'h80_FFF0_0003);
      cfg_write(10'h0C0, '0);  cfg_check("R2", 10'h0C0, 64'h2);
      cfg_write(10'h140, '1);  cfg_check("R3", 10'h140, 64'hFFF0_0000);
      cfg_write(10'h240, '1);  cfg_check("R3", 10'h240, 64'h7_FFFF_FC00);
      cfg_write(10'h300, '1);  cfg_check("R3", 10'h300, 64'h60);

      // main configuration
      cfg_write(10'h000, 64'h4000_0001); cfg_write(10'h100, 64'h1FF0_0000); cfg_write(10'h200, 64'h2_2000_0000);
      cfg_write(10'h040, 64'h8000_0003); cfg_write(10'h140, 64'h0);         cfg_write(10'h240, 64'h1_0000_0000);
      cfg_write(10'h080, 64'h0000_0001); cfg_write(10'h180, 64'h0);         cfg_write(10'h280, 64'h0700_0000);
      cfg_write(10'h0C0, 64'h0000_0001); cfg_write(10'h1C0, 64'hFFF0_0000); cfg_write(10'h2C0, 64'h40_0000);
      cfg_write(10'h300, 64'h60);

      for (int i = 0; i < 14; i++) begin
         xlat($sformatf("R%0d", VECS[i].req), VECS[i].addr, VECS[i].hit, VECS[i].pa,
              VECS[i].walk, VECS[i].pte);
      end

      // R6: hole cleared, window 2 translates the same range
      cfg_write(10'h300, 64'h40);
      xlat("R6", 64'h000A_BCDE, 1'b1, 35'h0_070A_BCDE, 1'b0, 35'h0);

      // R10: last window routed to dual-cycle addresses
      cfg_write(10'h0C0, 64'h80_0000_0001);
      xlat("R10", 64'h0000_0800_1234_0ABC, 1'b1, 35'h1_1234_0ABC, 1'b1, 35'h0_0044_8D00);
      xlat("R10", 64'h0000_1000_0000_0000, 1'b0, 35'h0, 1'b0, 35'h0);
      // R5: last window no longer serves single-cycle addresses
      xlat("R5", 64'h0000_0000_C000_6000, 1'b0, 35'h0, 1'b0, 35'h0);
      // R11: disabled window never matches
      cfg_write(10'h080, 64'h0);
      xlat("R11", 64'h0000_0000_0007_FFFF, 1'b0, 35'h0, 1'b0, 35'h0);
      // R10: routing bit set but window disabled
      cfg_write(10'h0C0, 64'h80_0000_0000);
      xlat("R10", 64'h0000_0800_1234_0ABC, 1'b0, 35'h0, 1'b0, 35'h0);

      // R12: response held under back-pressure
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h4123_4567;
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp();
      held = rsp_phys;
      chk("R12", "phys", 64'(held), 64'h2_2123_4567);
      repeat (3) begin
         @(negedge clk);
         chk("R12", "rsp_valid held", 64'(rsp_valid), 64'd1);
         chk("R12", "req_ready busy", 64'(req_ready), 64'd0);
         chk("R12", "phys stable", 64'(rsp_phys), 64'(held));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R12", "rsp_valid dropped", 64'(rsp_valid), 64'd0);
      chk("R12", "req_ready back", 64'(req_ready), 64'd1);

      // R7: memory request held while memory stalls
      mem_gate = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h8001_2345;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) begin
         chk("R7", "mem_req_valid held", 64'(mem_req_valid), 64'd1);
         chk("R7", "mem_req_addr held", 64'(mem_req_addr), 64'h1_0000_0048);
         chk("R7", "no early rsp", 64'(rsp_valid), 64'd0);
         @(negedge clk);
      end
      mem_gate = 1'b1;
      wait_rsp();
      chk("R7", "stalled hit", 64'(rsp_hit), 64'd1);
      chk("R7", "stalled phys", 64'(rsp_phys), 64'h1_2345);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;

      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end
endmodule